// File: doc/BRIEF.md
# Black-Level Offset Feedback Controller

This block closes the digital half of a black-level clamp loop for an image sensor front end. It watches the 12-bit converter output. When an optical-black pulse begins, it opens a fixed window of eight clocks, averages the samples inside that window and compares the average with a clamp target chosen by a 5-bit code. It then issues one signed correction word per line, together with a one-cycle strobe. The correction word drives a charge-pump current DAC that trims the analog offset.

After the gain setting changes, the loop runs in a lead-in mode for faster convergence. In this mode the normal correction is multiplied by a selectable power of two and saturated. Once the black-level error has stayed small for a selectable number of lines, the loop drops back to normal gain.

Top module: `blackFeedback`

## Requirements
- R1: While reset is asserted and after its release, `corrValid` is 0 and `corrOut` is 0 until the first completed window.
- R2: The effective black pulse is `obPulse XOR obInvert`, and a window starts only on a 0-to-1 transition of the effective pulse.
- R3: The clock edge that detects the transition counts as edge 0. The measured level is the sum of the samples present at edges 5 through 12, shifted right by 3. Samples at all other edges have no effect on the correction.
- R4: The clamp target in LSB is 56 + 8 × `clampCode`, so code 0 gives 56, code 9 gives 128 and code 31 gives 304.
- R5: At normal gain, `corrOut` is (target − average) arithmetically shifted right by 2, so it rounds toward minus infinity. It is written as 12-bit two's complement on edge 13, and `corrValid` is high for the cycle that follows.
- R6: In lead-in, the normal-gain value is additionally shifted left by `nSel`+1 (`nSel` 0,1,2,3 gives ×2, ×4, ×8, ×16). The result is saturated to the range −2048 to 2047.
- R7: A `gainChanged` pulse enters lead-in and clears the hold count. A line in lead-in whose |error| is 64 or less adds one to the count. A line whose |error| is above 64 clears the count. The line that brings the count to 2^`holdSel` (1, 2, 4 or 8) is still corrected in lead-in, and later lines use normal gain.
- R8: Exactly one correction strobe is produced per black pulse. It is never wider than one cycle, and no strobe appears without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 12 | Converter sample, unsigned |
| obPulse | input | 1 | Optical-black pulse pin |
| obInvert | input | 1 | Inverts the polarity of the black pulse |
| clampCode | input | 5 | Clamp target select |
| nSel | input | 2 | Lead-in multiplier select |
| holdSel | input | 2 | Lead-in exit hold-off select, in lines |
| gainChanged | input | 1 | One-cycle strobe that marks a change of gain setting |
| corrOut | output | 12 | Signed correction command |
| corrValid | output | 1 | Correction strobe, one cycle per line |

## Verification
The properties assume that each black pulse stays active for more than two clocks. They also assume that pulses are spaced so each window completes before the next transition, and that `clampCode`, `nSel` and `holdSel` stay stable while a window is open. The stimulus holds every pulse for four clocks within a twenty-clock line. It changes settings and polarity only during idle gaps, and it flips `obInvert` together with the pin so that the effective pulse shows no false edge. Window samples step around a chosen level, which exercises truncation in the average and floor behaviour in the shift. Junk values outside the window show that those samples are ignored.

// File: rtl/blackFbPkg.sv
package blackFbPkg;
  typedef struct packed {
    logic accClear;
    logic accEn;
    logic avgLoad;
    logic corrLoad;
    logic leadGain;
  } fbStrobes_t;
endpackage

// File: rtl/blackFbCtrl.sv
module blackFbCtrl
  import blackFbPkg::*;
#(
  parameter int WIN_START  = 5,
  parameter int WIN_LEN    = 8,
  parameter int HOLD_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  obPulse,
  input  logic                  obInvert,
  input  logic                  gainChanged,
  input  logic                  errLarge,
  input  logic [HOLD_SEL_W-1:0] holdSel,
  output fbStrobes_t            strobes
);
  localparam int WIN_END    = WIN_START + WIN_LEN - 1;
  localparam int CNT_W      = $clog2(WIN_END + 1);
  localparam int HOLD_CNT_W = (1 << HOLD_SEL_W);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(WIN_START);
  localparam logic [CNT_W-1:0] CNT_END   = CNT_W'(WIN_END);

  logic obEff, obPrev, obRise, corrPend, leadActive;
  logic [CNT_W-1:0] posCnt;
  logic [HOLD_CNT_W-1:0] holdCnt, holdLimit;

  assign obEff     = obPulse ^ obInvert;
  assign obRise    = obEff & ~obPrev;
  assign holdLimit = HOLD_CNT_W'(1) << holdSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obPrev   <= 1'b0;
      posCnt   <= '0;
      corrPend <= 1'b0;
    end else begin
      obPrev   <= obEff;
      corrPend <= (posCnt == CNT_END);
      if (obRise)
        posCnt <= CNT_W'(1);
      else if (posCnt != '0)
        posCnt <= (posCnt == CNT_END) ? '0 : posCnt + CNT_W'(1);
    end
  end

  // lead-in state: entered on gain change, left after a run of quiet lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leadActive <= 1'b0;
      holdCnt    <= '0;
    end else if (gainChanged) begin
      leadActive <= 1'b1;
      holdCnt    <= '0;
    end else if (corrPend && leadActive) begin
      if (errLarge)
        holdCnt <= '0;
      else if (holdCnt + HOLD_CNT_W'(1) == holdLimit) begin
        leadActive <= 1'b0;
        holdCnt    <= '0;
      end else
        holdCnt <= holdCnt + HOLD_CNT_W'(1);
    end
  end

  always_comb begin
    strobes.accClear = obRise;
    strobes.accEn    = (posCnt >= CNT_START) && (posCnt < CNT_END);
    strobes.avgLoad  = (posCnt == CNT_END);
    strobes.corrLoad = corrPend;
    strobes.leadGain = leadActive;
  end
endmodule

// File: rtl/blackFbData.sv
module blackFbData
  import blackFbPkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int CODE_W       = 5,
  parameter int WIN_LEN      = 8,
  parameter int CLAMP_BASE   = 56,
  parameter int CLAMP_STEP   = 8,
  parameter int NORM_SHIFT   = 2,
  parameter int LEAD_LIMIT   = 64,
  parameter int LEAD_MAX_LOG = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [DATA_W-1:0]               sampleIn,
  input  logic [CODE_W-1:0]               clampCode,
  input  logic [$clog2(LEAD_MAX_LOG)-1:0] nSel,
  input  fbStrobes_t                      strobes,
  output logic                            errLarge,
  output logic [DATA_W-1:0]               corrOut,
  output logic                            corrValid
);
  localparam int AVG_SHIFT = $clog2(WIN_LEN);
  localparam int ACC_W     = DATA_W + AVG_SHIFT;
  localparam int ERR_W     = DATA_W + 1;
  localparam int WIDE_W    = ERR_W + LEAD_MAX_LOG;
  localparam int SEL_W     = $clog2(LEAD_MAX_LOG);
  localparam logic signed [ERR_W-1:0]  LIM_P   = ERR_W'(LEAD_LIMIT);
  localparam logic signed [WIDE_W-1:0] SAT_MAX = WIDE_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] SAT_MIN = ~SAT_MAX;

  logic [ACC_W-1:0] acc, accSum;
  logic [DATA_W-1:0] avg, target, saturated;
  logic signed [ERR_W-1:0] err, normCorr;
  logic signed [WIDE_W-1:0] widened, boosted, chosen;
  logic [SEL_W:0] boostSh;

  assign accSum = acc + ACC_W'(sampleIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      avg <= '0;
    end else begin
      if (strobes.accClear)
        acc <= '0;
      else if (strobes.accEn)
        acc <= accSum;
      if (strobes.avgLoad)
        avg <= DATA_W'(accSum >> AVG_SHIFT);
    end
  end

  always_comb begin
    target    = DATA_W'(CLAMP_BASE) + DATA_W'(CLAMP_STEP) * DATA_W'(clampCode);
    err       = $signed({1'b0, target}) - $signed({1'b0, avg});
    errLarge  = (err > LIM_P) || (err < -LIM_P);
    normCorr  = err >>> NORM_SHIFT;
    widened   = WIDE_W'(normCorr);
    boostSh   = {1'b0, nSel} + (SEL_W + 1)'(1);
    boosted   = widened <<< boostSh;
    chosen    = strobes.leadGain ? boosted : widened;
    if (chosen > SAT_MAX)
      saturated = SAT_MAX[DATA_W-1:0];
    else if (chosen < SAT_MIN)
      saturated = SAT_MIN[DATA_W-1:0];
    else
      saturated = chosen[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrOut   <= '0;
      corrValid <= 1'b0;
    end else begin
      corrValid <= strobes.corrLoad;
      if (strobes.corrLoad)
        corrOut <= saturated;
    end
  end
endmodule

// File: rtl/blackFeedback.sv
module blackFeedback
  import blackFbPkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int CODE_W       = 5,
  parameter int WIN_START    = 5,
  parameter int WIN_LEN      = 8,
  parameter int CLAMP_BASE   = 56,
  parameter int CLAMP_STEP   = 8,
  parameter int NORM_SHIFT   = 2,
  parameter int LEAD_LIMIT   = 64,
  parameter int LEAD_MAX_LOG = 4,
  parameter int HOLD_SEL_W   = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [DATA_W-1:0]               sampleIn,
  input  logic                            obPulse,
  input  logic                            obInvert,
  input  logic [CODE_W-1:0]               clampCode,
  input  logic [$clog2(LEAD_MAX_LOG)-1:0] nSel,
  input  logic [HOLD_SEL_W-1:0]           holdSel,
  input  logic                            gainChanged,
  output logic [DATA_W-1:0]               corrOut,
  output logic                            corrValid
);
  fbStrobes_t strobes;
  logic errLarge;
  logic leadActive;

  assign leadActive = strobes.leadGain;

  blackFbCtrl #(
    .WIN_START(WIN_START), .WIN_LEN(WIN_LEN), .HOLD_SEL_W(HOLD_SEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .obPulse(obPulse), .obInvert(obInvert),
    .gainChanged(gainChanged), .errLarge(errLarge), .holdSel(holdSel),
    .strobes(strobes)
  );

  blackFbData #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .WIN_LEN(WIN_LEN),
    .CLAMP_BASE(CLAMP_BASE), .CLAMP_STEP(CLAMP_STEP), .NORM_SHIFT(NORM_SHIFT),
    .LEAD_LIMIT(LEAD_LIMIT), .LEAD_MAX_LOG(LEAD_MAX_LOG)
  ) u_data (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .clampCode(clampCode),
    .nSel(nSel), .strobes(strobes), .errLarge(errLarge),
    .corrOut(corrOut), .corrValid(corrValid)
  );
endmodule

// File: rtl/blackFeedbackChk.sv
module blackFeedbackChk #(
  parameter int DATA_W     = 12,
  parameter int CODE_W     = 5,
  parameter int CLAMP_BASE = 56,
  parameter int CLAMP_STEP = 8,
  parameter int NORM_SHIFT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              corrValid,
  input logic [DATA_W-1:0] corrOut,
  input logic              gainChanged,
  input logic              leadActive,
  input logic              corrLoad
);
  localparam int NORM_MAX = (CLAMP_BASE + CLAMP_STEP * ((1 << CODE_W) - 1)) >> NORM_SHIFT;
  localparam int NORM_MIN = -(((1 << DATA_W) - 1 + (1 << NORM_SHIFT) - 1) >> NORM_SHIFT);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !corrValid);

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    corrValid |=> !corrValid);

  // R5
  strobe_follows_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    corrLoad |=> corrValid);

  // R5
  normal_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (corrValid && !$past(leadActive)) |->
      ($signed(corrOut) <= NORM_MAX && $signed(corrOut) >= NORM_MIN));

  // R7
  lead_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    gainChanged |=> leadActive);
endmodule

bind blackFeedback blackFeedbackChk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .CLAMP_BASE(CLAMP_BASE),
  .CLAMP_STEP(CLAMP_STEP), .NORM_SHIFT(NORM_SHIFT)
) u_chk (
  .clk(clk), .rstN(rstN), .corrValid(corrValid), .corrOut(corrOut),
  .gainChanged(gainChanged), .leadActive(leadActive),
  .corrLoad(strobes.corrLoad)
);

// File: tb/blackFeedback_tb.sv
module blackFeedback_tb;
  logic clk = 0;
  logic rstN = 0;
  logic [11:0] sampleIn = 0;
  logic obPulse = 0, obInvert = 0, gainChanged = 0;
  logic [4:0] clampCode = 9;
  logic [1:0] nSel = 0, holdSel = 0;
  logic [11:0] corrOut;
  logic corrValid;

  int checks = 0, failures = 0;
  int expQ[$];
  string tagQ[$];
  int modelLead = 0, modelHold = 0;
  bit prevValid = 0, done = 0;

  always #5 clk = ~clk;

  blackFeedback u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .obPulse(obPulse),
    .obInvert(obInvert), .clampCode(clampCode), .nSel(nSel),
    .holdSel(holdSel), .gainChanged(gainChanged),
    .corrOut(corrOut), .corrValid(corrValid)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as strobes appear
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (corrValid) begin
        check("R8 strobe width", int'(prevValid), 0);
        if (expQ.size() == 0) begin
          check("R8 unexpected strobe", 1, 0);
        end else begin
          automatic int e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(t, int'($signed(corrOut)), e);
        end
      end
      prevValid = corrValid;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleIn = 12'(4000 - i);
    end
  endtask

  task automatic pulseGain();
    @(negedge clk);
    gainChanged = 1;
    modelLead = 1;
    modelHold = 0;
    @(negedge clk);
    gainChanged = 0;
  endtask

  // driver: one line with a pulse; pushes the expected correction
  task automatic runLine(int lvl, int spread, string tag);
    int sum = 0;
    for (int i = 0; i < 20; i++) begin
      int v;
      @(negedge clk);
      if (i >= 5 && i <= 12) begin
        v = lvl + spread * (i - 8);
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        sum += v;
      end else begin
        v = 4095 - 3 * i;
      end
      sampleIn = 12'(v);
      obPulse = (i < 4) ^ obInvert;
      if (i == 12) begin
        int target, avg, err, sh, c;
        target = 56 + 8 * int'(clampCode);
        avg = sum / 8;
        err = target - avg;
        sh = err >>> 2;
        if (modelLead != 0) begin
          c = sh * (1 << (int'(nSel) + 1));
          if (c > 2047) c = 2047;
          if (c < -2048) c = -2048;
        end else begin
          c = sh;
        end
        expQ.push_back(c);
        tagQ.push_back(tag);
        if (modelLead != 0) begin
          if (err > 64 || err < -64) modelHold = 0;
          else begin
            modelHold++;
            if (modelHold == (1 << int'(holdSel))) begin
              modelLead = 0;
              modelHold = 0;
            end
          end
        end
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(corrValid), 0);
    check("R1 out in reset", int'(corrOut), 0);
    rstN = 1;
    idle(5);
    check("R1 valid after reset", int'(corrValid), 0);
    check("R1 out after reset", int'(corrOut), 0);

    clampCode = 9;
    runLine(100, 0, "R4/R5 code9 level100");
    runLine(200, 3, "R3/R5 stepped window floor");
    runLine(128, 7, "R3 truncated average");
    clampCode = 0;
    idle(2);
    runLine(60, 1, "R4 code0");
    clampCode = 31;
    idle(2);
    runLine(4000, 0, "R4/R5 code31 large");
    runLine(10, 2, "R5 positive error");
    idle(30);

    @(negedge clk);
    obInvert = 1;
    obPulse = 1;
    clampCode = 9;
    idle(3);
    runLine(300, 2, "R2 inverted pulse");
    runLine(90, 0, "R2 inverted pulse second");
    @(negedge clk);
    obInvert = 0;
    obPulse = 0;
    idle(3);

    holdSel = 0;
    for (int k = 0; k < 4; k++) begin
      nSel = 2'(k);
      pulseGain();
      runLine(1000, 0, "R6 lead multiplier and saturation");
    end
    runLine(130, 0, "R7 quiet line still lead");
    runLine(130, 0, "R7 normal after hold 1");

    nSel = 1;
    holdSel = 1;
    pulseGain();
    runLine(140, 0, "R7 hold2 quiet 1");
    runLine(120, 0, "R7 hold2 quiet 2");
    runLine(140, 0, "R7 normal after hold 2");

    nSel = 2;
    holdSel = 2;
    pulseGain();
    runLine(130, 0, "R7 hold4 quiet a");
    runLine(130, 0, "R7 hold4 quiet b");
    runLine(400, 0, "R7 large error restarts");
    runLine(130, 0, "R7 hold4 quiet 1");
    runLine(130, 0, "R7 hold4 quiet 2");
    runLine(130, 0, "R7 hold4 quiet 3");
    runLine(130, 0, "R7 hold4 quiet 4");
    runLine(130, 0, "R7 normal after hold 4");

    idle(40);
    check("R8 all expected strobes seen", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule